// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks which physical frame gives up its page when a new page has to be brought in. It keeps a small amount of state for each of N frames: an occupied flag and a reference bit. A pulse on the access-notify input sets a frame's reference bit whenever that frame is used. The frames form a ring, and a hand pointer marks the next frame to be considered for eviction.

When a victim is requested and a frame has never been filled since reset, the block answers at once with the lowest-numbered empty frame. Once all frames are full, the hand walks the ring and looks at one frame per clock. A frame whose reference bit is set loses that bit, and the hand moves on. The first frame found with a clear bit becomes the victim, and the hand stops one position past it. The victim's reference bit is left clear for the newly installed page. If every bit is set, the hand goes all the way round, clearing each one, and then picks the frame it started on, so the choice is the same as first-in first-out order.

The block only reports frame numbers. The caller keeps the page-to-frame map and decides when an access counts as a fault.

Top module: `clock_victim_sel`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are low, every frame is empty, every reference bit is clear, and the hand points at frame 0.
- R2: A request accepted while a frame is still empty returns the lowest-numbered empty frame, with `done` high in the cycle after the request. `busy` stays low, no sweep happens, and the hand does not move.
- R3: During a sweep the block looks at the frame under the hand, one frame per clock. A frame with its reference bit set has the bit cleared, and the hand moves to the next frame, wrapping from N-1 to 0.
- R4: The first frame looked at whose reference bit is clear becomes the victim. `done` goes high for one cycle, carrying that index on `victim_idx`, in the cycle after the frame was looked at. The latency from request to `done` is therefore one cycle more than the number of frames looked at.
- R5: After a sweep picks a victim, the hand points at the victim index plus one (modulo N), and the victim's reference bit is clear.
- R6: With every frame full and every reference bit set, the sweep looks at N+1 frames and returns the frame the hand started on.
- R7: An access-notify pulse (`touch_valid` with `touch_idx`) sets that frame's reference bit. It takes priority over a clear that the sweep applies to the same frame in the same cycle. An index of N or above has no effect.
- R8: A request that arrives while `busy` is high is ignored. No second `done` follows.
- R9: `busy` is high from the cycle after a request that starts a sweep until the cycle in which `done` is raised, and `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| touch_valid | input | 1 | Access-notify strobe: sets the reference bit of `touch_idx` |
| touch_idx | input | IDX_W | Frame that was accessed |
| req | input | 1 | Request a victim frame (ignored while busy) |
| busy | output | 1 | A sweep is in progress |
| done | output | 1 | One-cycle pulse: `victim_idx` is valid |
| victim_idx | output | IDX_W | Chosen frame index |

## Verification
The sweep's clear of the reference bit under the hand and an access-notify to that same frame can fall in the same clock cycle. The bench provokes this with three full frames whose reference bits are all set. It requests a victim and then raises the notify for frame 0 in exactly the cycle the hand looks at frame 0. Frame 0 must therefore survive the first pass: the expected victim is frame 1, reported six cycles after the request. If the clear had won, frame 0 would be reported one cycle earlier. A second request, pulsed in the middle of that sweep, must not produce a further `done`.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } sel_state_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_FILL  = 2'd1,
        ACT_SKIP  = 2'd2,
        ACT_PICK  = 2'd3
    } sel_act_e;

    function automatic int unsigned idx_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/csel_ref_bits.sv
module csel_ref_bits #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         touch_valid,
    input  logic [W-1:0] touch_idx,
    input  logic         clr_valid,
    input  logic [W-1:0] clr_idx,
    output logic [N-1:0] ref_q
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (touch_valid && touch_idx == W'(g)) begin
                bit_q <= 1'b1;
            end else if (clr_valid && clr_idx == W'(g)) begin
                bit_q <= 1'b0;
            end
        end
        assign ref_q[g] = bit_q;
    end

endmodule

// File: rtl/csel_occupancy.sv
module csel_occupancy #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fill_valid,
    input  logic [W-1:0] fill_idx,
    output logic [N-1:0] occ_q,
    output logic         any_free,
    output logic [W-1:0] free_idx
);

    for (genvar g = 0; g < N; g++) begin : g_occ
        logic taken_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                taken_q <= 1'b0;
            end else if (fill_valid && fill_idx == W'(g)) begin
                taken_q <= 1'b1;
            end
        end
        assign occ_q[g] = taken_q;
    end

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!occ_q[i]) begin
                any_free = 1'b1;
                free_idx = W'(i);
            end
        end
    end

endmodule

// File: rtl/csel_hand_ctl.sv
module csel_hand_ctl
    import csel_pkg::*;
#(
    parameter int unsigned N = 4,
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic         any_free,
    input  logic [W-1:0] free_idx,
    input  logic [N-1:0] ref_q,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] victim_idx,
    output logic [W-1:0] hand,
    output logic         clr_valid,
    output logic [W-1:0] clr_idx,
    output logic         fill_valid,
    output logic [W-1:0] fill_idx
);

    localparam logic [W-1:0] LAST = W'(N - 1);

    sel_state_e   state_q, state_d;
    sel_act_e     act;
    logic [W-1:0] hand_q, hand_nx;
    logic         done_q;
    logic [W-1:0] victim_q;

    assign hand_nx = (hand_q == LAST) ? '0 : hand_q + 1'b1;

    always_comb begin
        act     = ACT_NONE;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (any_free) act = ACT_FILL;
                    else          state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (ref_q[hand_q]) begin
                    act = ACT_SKIP;
                end else begin
                    act     = ACT_PICK;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign clr_valid  = (act == ACT_SKIP) || (act == ACT_PICK);
    assign clr_idx    = hand_q;
    assign fill_valid = (act == ACT_FILL);
    assign fill_idx   = free_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            hand_q   <= '0;
            done_q   <= 1'b0;
            victim_q <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= (act == ACT_FILL) || (act == ACT_PICK);
            if (act == ACT_SKIP || act == ACT_PICK) begin
                hand_q <= hand_nx;
            end
            if (act == ACT_FILL) begin
                victim_q <= free_idx;
            end else if (act == ACT_PICK) begin
                victim_q <= hand_q;
            end
        end
    end

    assign busy       = (state_q == ST_SCAN);
    assign done       = done_q;
    assign victim_idx = victim_q;
    assign hand       = hand_q;

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
    import csel_pkg::*;
#(
    parameter int unsigned NFRAMES = 4,
    parameter int unsigned IDX_W   = idx_width(NFRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_valid,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             req,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] victim_idx
);

    logic [NFRAMES-1:0] ref_w;
    logic [NFRAMES-1:0] occ_w;
    logic               any_free_w;
    logic [IDX_W-1:0]   free_idx_w;
    logic [IDX_W-1:0]   hand_w;
    logic               clr_valid_w;
    logic [IDX_W-1:0]   clr_idx_w;
    logic               fill_valid_w;
    logic [IDX_W-1:0]   fill_idx_w;

    csel_ref_bits #(.N(NFRAMES), .W(IDX_W)) u_refs (
        .clk         (clk),
        .rst         (rst),
        .touch_valid (touch_valid),
        .touch_idx   (touch_idx),
        .clr_valid   (clr_valid_w),
        .clr_idx     (clr_idx_w),
        .ref_q       (ref_w)
    );

    csel_occupancy #(.N(NFRAMES), .W(IDX_W)) u_occ (
        .clk        (clk),
        .rst        (rst),
        .fill_valid (fill_valid_w),
        .fill_idx   (fill_idx_w),
        .occ_q      (occ_w),
        .any_free   (any_free_w),
        .free_idx   (free_idx_w)
    );

    csel_hand_ctl #(.N(NFRAMES), .W(IDX_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .any_free   (any_free_w),
        .free_idx   (free_idx_w),
        .ref_q      (ref_w),
        .busy       (busy),
        .done       (done),
        .victim_idx (victim_idx),
        .hand       (hand_w),
        .clr_valid  (clr_valid_w),
        .clr_idx    (clr_idx_w),
        .fill_valid (fill_valid_w),
        .fill_idx   (fill_idx_w)
    );

endmodule

// File: rtl/csel_checker.sv
module csel_checker #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         touch_valid,
    input logic [W-1:0] touch_idx,
    input logic         req,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] victim_idx,
    input logic [W-1:0] hand,
    input logic [N-1:0] ref_bits,
    input logic [N-1:0] occ
);

    function automatic logic [W-1:0] step(logic [W-1:0] i);
        return (i == W'(N - 1)) ? '0 : i + 1'b1;
    endfunction

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && hand == '0 && ref_bits == '0));

    // R2
    a_r2_free_fast: assert property (@(posedge clk) disable iff (rst)
        (!busy && req && !(&occ)) |=> (done && !busy));

    // R3
    a_r3_hand_steps: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> hand == step($past(hand)));

    // R5
    a_r5_hand_past_victim: assert property (@(posedge clk) disable iff (rst)
        (done && $past(busy)) |-> (hand == step(victim_idx) && !ref_bits[victim_idx]));

    // R7
    a_r7_touch_wins: assert property (@(posedge clk) disable iff (rst)
        (touch_valid && touch_idx < W'(N)) |=> ref_bits[$past(touch_idx)]);

    // R9
    a_r9_busy_done_apart: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind clock_victim_sel csel_checker #(.N(NFRAMES), .W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .touch_valid (touch_valid),
    .touch_idx   (touch_idx),
    .req         (req),
    .busy        (busy),
    .done        (done),
    .victim_idx  (victim_idx),
    .hand        (hand_w),
    .ref_bits    (ref_w),
    .occ         (occ_w)
);

// File: tb/sim_clock_victim_sel.sv
module sim_clock_victim_sel;

    localparam int N = 3;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         touch_valid = 1'b0;
    logic [W-1:0] touch_idx = '0;
    logic         req = 1'b0;
    logic         busy;
    logic         done;
    logic [W-1:0] victim_idx;

    int checks = 0;
    int errors = 0;

    bit m_ref [N];
    bit m_occ [N];
    int m_hand;
    int m_page [N];

    always #5 clk = ~clk;

    clock_victim_sel #(.NFRAMES(N), .IDX_W(W)) u0 (
        .clk(clk), .rst(rst), .touch_valid(touch_valid), .touch_idx(touch_idx),
        .req(req), .busy(busy), .done(done), .victim_idx(victim_idx)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_ref[i] = 0; m_occ[i] = 0; m_page[i] = -1;
        end
        m_hand = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        model_reset();
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
    endtask

    task automatic touch(int f);
        touch_valid = 1'b1;
        touch_idx   = W'(f);
        tick();
        touch_valid = 1'b0;
        if (f < N) m_ref[f] = 1;
    endtask

    // model prediction per requirements R2..R6
    task automatic predict(output int vic, output int lat);
        int free_f = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_occ[i]) free_f = i;
        if (free_f >= 0) begin
            vic = free_f; lat = 1;
            m_occ[free_f] = 1; m_ref[free_f] = 0;
        end else begin
            int h = m_hand;
            int steps = 0;
            vic = -1;
            while (vic < 0) begin
                steps++;
                if (m_ref[h]) begin
                    m_ref[h] = 0;
                    h = (h + 1) % N;
                end else begin
                    vic = h;
                end
            end
            lat = 1 + steps;
            m_hand = (vic + 1) % N;
            m_ref[vic] = 0;
        end
    endtask

    task automatic request(output int vic, output int lat);
        req = 1'b1;
        tick();
        req = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            tick();
            lat++;
        end
        vic = int'(victim_idx);
    endtask

    task automatic req_and_check(string tag, output int vic);
        int ev, el, lat;
        predict(ev, el);
        request(vic, lat);
        check(vic == ev, {tag, " victim"}, vic, ev);
        check(lat == el, {tag, " latency"}, lat, el);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, lat, start;
        int faults, fifo_faults;
        int refs [16] = '{0,1,2,3,0,1,2,3,0,1,2,3,4,5,6,7};
        int q [$];

        // Phase A
        do_reset();
        for (int i = 0; i < N; i++) begin
            req_and_check("R2 fill lowest free", v);
            check(v == i, "R2 fill order", v, i);
            check(busy == 1'b0, "R2 no sweep", int'(busy), 0);
        end
        req_and_check("R4 clear bit picked", v);
        check(v == 0, "R4 first clear frame", v, 0);
        req_and_check("R5 hand past victim", v);
        check(v == 1, "R5 next victim", v, 1);
        touch(2); touch(0);
        req_and_check("R3 skip and wrap", v);
        check(v == 1, "R3 wrap victim", v, 1);
        touch(0); touch(1); touch(2);
        start = m_hand;
        req_and_check("R6 all set", v);
        check(v == start, "R6 returns start frame", v, start);
        touch(3);
        req_and_check("R7 out-of-range touch ignored", v);

        // Phase B: touch colliding with sweep clear, and request while busy
        do_reset();
        for (int i = 0; i < N; i++) req_and_check("R2 refill", v);
        touch(0); touch(1); touch(2);
        req = 1'b1;
        tick();
        req = 1'b0;
        touch_valid = 1'b1; touch_idx = 2'd0;
        tick();
        touch_valid = 1'b0;
        check(busy == 1'b1, "R9 busy during sweep", int'(busy), 1);
        req = 1'b1;
        tick();
        req = 1'b0;
        lat = 3;
        while (!done && lat < 40) begin
            tick();
            lat++;
        end
        check(int'(victim_idx) == 1, "R7 touch beats clear victim", int'(victim_idx), 1);
        check(lat == 6, "R7 touch beats clear latency", lat, 6);
        check(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
        tick();
        check(done == 1'b0, "R8 no second done", int'(done), 0);
        check(busy == 1'b0, "R8 no second sweep", int'(busy), 0);
        tick();
        check(done == 1'b0, "R8 still idle", int'(done), 0);

        // Phase C: reference string, fault count
        do_reset();
        faults = 0;
        foreach (refs[k]) begin
            int hit_f = -1;
            for (int i = 0; i < N; i++) if (m_page[i] == refs[k]) hit_f = i;
            if (hit_f >= 0) begin
                touch(hit_f);
            end else begin
                faults++;
                req_and_check("R6 reference string", v);
                if (v >= 0 && v < N) begin
                    m_page[v] = refs[k];
                    touch(v);
                end
            end
        end
        fifo_faults = 0;
        foreach (refs[k]) begin
            bit hit = 0;
            foreach (q[j]) if (q[j] == refs[k]) hit = 1;
            if (!hit) begin
                fifo_faults++;
                if (q.size() == N) void'(q.pop_front());
                q.push_back(refs[k]);
            end
        end
        check(faults == fifo_faults, "R6 fault count vs FIFO", faults, fifo_faults);
        check(faults == 16, "R6 fault count", faults, 16);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule